// File: doc/BRIEF.md
# Byte-Lane Bank Decoder for a 1 MB Bus Memory Module

This block sits between a 24-bit parallel system bus and a 1 MB memory module built from eight banks. Each bank is 64K words of 16 bits, made from two byte-wide 64K devices: one carries the low byte and one carries the high byte. The decoder watches the bus address, the active-low read and write command strobes and the active-low byte-high enable. It produces one active-low chip select per device, which is eight low-lane selects and eight high-lane selects. It also drives the module-select line, which enables the module's address and data buffers, and the direction line of the bidirectional data buffer.

The module occupies a fixed 1 MB window that starts at address C0000h. The base only has to be aligned to one bank, so it is reduced to the window offset by subtraction and not by a plain match on the high address bits. Offset bits 17 to 19 pick the bank. Address bit 0 and the byte-high enable pick the byte lanes, so an access can be a whole word, the even byte or the odd byte. The block is purely combinational, and every output follows its inputs in the same cycle. It has no data stream, so it has no valid/ready handshake and no back-pressure. All pins are plain control levels.

Top module: `membank_decoder`

## Requirements
- R1: The module select `mod_sel_n` is low exactly when the address lies in [BASE, BASE + 2^20) and at least one command strobe (`rd_cmd_n` or `wr_cmd_n`) is low. BASE defaults to 0x0C0000.
- R2: An address below BASE or at BASE + 2^20 and above drives every chip select high and leaves `mod_sel_n` high, whatever the strobes and the byte-high enable are.
- R3: With both command strobes high, all sixteen chip selects and `mod_sel_n` are high.
- R4: The selected bank index is (address − BASE) >> 17, in the range 0..7. Only chip selects with that index may be low.
- R5: The low-lane select of the chosen bank (`bank_lo_cs_n[k]`) is low exactly when the module is selected and address bit 0 is 0.
- R6: The high-lane select of the chosen bank (`bank_hi_cs_n[k]`) is low exactly when the module is selected and `bhe_n` is 0.
- R7: A word access (bit 0 = 0, `bhe_n` = 0) lowers both lanes of the same bank. An odd-address access with `bhe_n` = 0 lowers only the high lane. An even access with `bhe_n` = 1 lowers only the low lane. Bit 0 = 1 with `bhe_n` = 1 lowers nothing.
- R8: `buf_to_bus` is 1 exactly when `rd_cmd_n` is low, whatever the address.
- R9: At most one low-lane select and at most one high-lane select are low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 24 | Bus byte address |
| rd_cmd_n | input | 1 | Memory read command strobe, active low |
| wr_cmd_n | input | 1 | Memory write command strobe, active low |
| bhe_n | input | 1 | Byte-high enable, active low |
| bank_lo_cs_n | output | 8 | Low-byte device selects, one per bank, active low |
| bank_hi_cs_n | output | 8 | High-byte device selects, one per bank, active low |
| mod_sel_n | output | 1 | Module select enabling address and data buffers, active low |
| buf_to_bus | output | 1 | Data buffer direction, 1 drives the module's data onto the bus |

## Verification
The hardest cases to reach are the window edges. The base is not aligned to 1 MB, so the window straddles a change in the top address nibble, and an off-by-one in the offset subtraction or the borrow test only shows on a handful of addresses. The bench sweeps every combination of address bits 17 to 23 with all sixteen strobe, byte-enable and bit-0 settings, which covers every bank-sized slot inside and outside the window. It then drives the exact addresses one below the base, at the base, at the last byte of the window and one past it, under each control setting.

// File: rtl/membank_dec_pkg.sv
package membank_dec_pkg;

  // Request for the two byte lanes of one bank.
  typedef struct packed {
    logic hi;
    logic lo;
  } lane_req_t;

  // Bus command decoded from the strobes.
  typedef struct packed {
    logic rd;
    logic wr;
  } bus_cmd_t;

endpackage

// File: rtl/membank_window.sv
module membank_window #(
  parameter int unsigned         ADDR_W  = 24,
  parameter int unsigned         BANK_AW = 17,
  parameter int unsigned         SEL_W   = 3,
  parameter logic [ADDR_W-1:0]   BASE    = 24'h0C0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEL_W-1:0]  bank_idx
);

  localparam int unsigned WIN_AW = BANK_AW + SEL_W;
  localparam int unsigned HI_W   = ADDR_W - BANK_AW;

  // Base is bank aligned, so only the bits above the bank offset take part.
  logic [HI_W:0] diff;
  logic          borrow;
  logic          above_win;

  always_comb begin
    diff      = {1'b0, addr[ADDR_W-1:BANK_AW]} - {1'b0, BASE[ADDR_W-1:BANK_AW]};
    borrow    = diff[HI_W];
    above_win = |diff[HI_W-1:SEL_W];
    hit       = !borrow && !above_win;
    bank_idx  = diff[SEL_W-1:0];
  end

  // R1: a hit implies the address is not below the base.
  always_comb begin
    if (hit) begin
      p_hit_not_below_base_r1: assert (addr >= BASE);
    end
  end

  // R2: a hit implies the address is below the window's upper edge.
  always_comb begin
    if (hit) begin
      p_hit_below_top_r2: assert ({1'b0, addr} < ({1'b0, BASE} + (25'd1 << WIN_AW)));
    end
  end

endmodule

// File: rtl/membank_bank_sel.sv
module membank_bank_sel #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                 en,
  input  logic [SEL_W-1:0]     idx,
  output logic [NUM_BANKS-1:0] onehot
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign onehot[b] = en && (idx == SEL_W'(b));
  end

  // R9: never more than one bank enabled.
  always_comb begin
    p_one_bank_r9: assert ($onehot0(onehot));
  end

  // R3, R4: an enabled bank exists only when enabled.
  always_comb begin
    if (|onehot) begin
      p_bank_needs_en_r4: assert (en);
    end
  end

endmodule

// File: rtl/membank_lane_gate.sv
module membank_lane_gate
  import membank_dec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [NUM_BANKS-1:0] bank_on,
  input  lane_req_t            lanes,
  output logic [NUM_BANKS-1:0] lo_cs_n,
  output logic [NUM_BANKS-1:0] hi_cs_n
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    assign lo_cs_n[b] = !(bank_on[b] && lanes.lo);
    assign hi_cs_n[b] = !(bank_on[b] && lanes.hi);
  end

  // R7: lanes driven low in the same bank only.
  always_comb begin
    if (!(&lo_cs_n) && !(&hi_cs_n)) begin
      p_word_same_bank_r7: assert (lo_cs_n == hi_cs_n);
    end
  end

endmodule

// File: rtl/membank_decoder.sv
module membank_decoder
  import membank_dec_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       BANK_AW   = 17,
  parameter int unsigned       NUM_BANKS = 8,
  parameter logic [ADDR_W-1:0] BASE      = 24'h0C0000
) (
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 rd_cmd_n,
  input  logic                 wr_cmd_n,
  input  logic                 bhe_n,
  output logic [NUM_BANKS-1:0] bank_lo_cs_n,
  output logic [NUM_BANKS-1:0] bank_hi_cs_n,
  output logic                 mod_sel_n,
  output logic                 buf_to_bus
);

  localparam int unsigned SEL_W = $clog2(NUM_BANKS);

  bus_cmd_t        cmd;
  lane_req_t       lanes;
  logic            win_hit;
  logic [SEL_W-1:0] bank_idx;
  logic            selected;
  logic [NUM_BANKS-1:0] bank_on;
  logic            unused_addr_bits;

  assign unused_addr_bits = ^bus_addr[BANK_AW-1:1];

  always_comb begin
    cmd.rd   = !rd_cmd_n;
    cmd.wr   = !wr_cmd_n;
    lanes.lo = !bus_addr[0];
    lanes.hi = !bhe_n;
  end

  membank_window #(
    .ADDR_W (ADDR_W),
    .BANK_AW(BANK_AW),
    .SEL_W  (SEL_W),
    .BASE   (BASE)
  ) u_window (
    .addr    (bus_addr),
    .hit     (win_hit),
    .bank_idx(bank_idx)
  );

  assign selected   = win_hit && (cmd.rd || cmd.wr);
  assign mod_sel_n  = !selected;
  assign buf_to_bus = cmd.rd;

  membank_bank_sel #(
    .NUM_BANKS(NUM_BANKS),
    .SEL_W    (SEL_W)
  ) u_bank (
    .en    (selected),
    .idx   (bank_idx),
    .onehot(bank_on)
  );

  membank_lane_gate #(
    .NUM_BANKS(NUM_BANKS)
  ) u_lanes (
    .bank_on(bank_on),
    .lanes  (lanes),
    .lo_cs_n(bank_lo_cs_n),
    .hi_cs_n(bank_hi_cs_n)
  );

  // R3: module select requires a command strobe.
  always_comb begin
    if (!mod_sel_n) begin
      p_sel_needs_cmd_r3: assert (!rd_cmd_n || !wr_cmd_n);
    end
  end

  // R2: any chip select implies the module is selected.
  always_comb begin
    if (!(&bank_lo_cs_n) || !(&bank_hi_cs_n)) begin
      p_cs_needs_sel_r2: assert (!mod_sel_n);
    end
  end

  // R5: low lane only on even addresses.
  always_comb begin
    if (!(&bank_lo_cs_n)) begin
      p_lo_even_r5: assert (!bus_addr[0]);
    end
  end

  // R6: high lane only with the byte-high enable.
  always_comb begin
    if (!(&bank_hi_cs_n)) begin
      p_hi_bhe_r6: assert (!bhe_n);
    end
  end

  // R9: one device per lane at most.
  always_comb begin
    p_lane_onehot_r9: assert ($onehot0(~bank_lo_cs_n) && $onehot0(~bank_hi_cs_n));
  end

endmodule

// File: tb/tb_membank_decoder.sv
module tb_membank_decoder;

  localparam int unsigned ADDR_W = 24;
  localparam int unsigned NB     = 8;
  localparam int unsigned BASE   = 24'h0C0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [ADDR_W-1:0] bus_addr;
  logic rd_cmd_n, wr_cmd_n, bhe_n;
  logic [NB-1:0] bank_lo_cs_n, bank_hi_cs_n;
  logic mod_sel_n, buf_to_bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  membank_decoder dut (
    .bus_addr    (bus_addr),
    .rd_cmd_n    (rd_cmd_n),
    .wr_cmd_n    (wr_cmd_n),
    .bhe_n       (bhe_n),
    .bank_lo_cs_n(bank_lo_cs_n),
    .bank_hi_cs_n(bank_hi_cs_n),
    .mod_sel_n   (mod_sel_n),
    .buf_to_bus  (buf_to_bus)
  );

  task automatic apply(input logic [ADDR_W-1:0] a, input logic [3:0] ctl);
    int unsigned in_win, sel, bank;
    logic [NB-1:0] exp_lo, exp_hi;
    logic exp_mod, exp_dir;
    @(negedge clk);
    bus_addr = a;
    rd_cmd_n = ctl[0];
    wr_cmd_n = ctl[1];
    bhe_n    = ctl[2];
    #2;
    in_win  = (int'(a) >= BASE && int'(a) < BASE + (1 << 20)) ? 1 : 0;
    sel     = (in_win != 0 && (!ctl[0] || !ctl[1])) ? 1 : 0;
    bank    = (int'(a) - BASE) >> 17;
    exp_lo  = '1;
    exp_hi  = '1;
    if (sel != 0) begin
      if (!a[0]) exp_lo[bank[2:0]] = 1'b0;
      if (!ctl[2]) exp_hi[bank[2:0]] = 1'b0;
    end
    exp_mod = (sel == 0);
    exp_dir = !ctl[0];
    checks++;
    if (mod_sel_n !== exp_mod) begin
      fails++;
      $display("FAIL R1/R2/R3 mod_sel_n addr=%h ctl=%b got %b exp %b", a, ctl, mod_sel_n, exp_mod);
    end
    checks++;
    if (bank_lo_cs_n !== exp_lo) begin
      fails++;
      $display("FAIL R4/R5/R7 lo_cs addr=%h ctl=%b got %b exp %b", a, ctl, bank_lo_cs_n, exp_lo);
    end
    checks++;
    if (bank_hi_cs_n !== exp_hi) begin
      fails++;
      $display("FAIL R4/R6/R7 hi_cs addr=%h ctl=%b got %b exp %b", a, ctl, bank_hi_cs_n, exp_hi);
    end
    checks++;
    if (buf_to_bus !== exp_dir) begin
      fails++;
      $display("FAIL R8 buf_to_bus addr=%h ctl=%b got %b exp %b", a, ctl, buf_to_bus, exp_dir);
    end
    checks++;
    if (!$onehot0(~bank_lo_cs_n) || !$onehot0(~bank_hi_cs_n)) begin
      fails++;
      $display("FAIL R9 onehot lo=%b hi=%b exp at most one low each", bank_lo_cs_n, bank_hi_cs_n);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [ADDR_W-1:0] edges [4];
    bus_addr = '0;
    rd_cmd_n = 1'b1;
    wr_cmd_n = 1'b1;
    bhe_n    = 1'b1;
    // R3 idle state: no strobes, in-window address.
    apply(24'h0C0000, 4'b0111);
    // R1..R9 sweep: every bank-sized slot of the 24-bit space, all controls.
    for (int hi = 0; hi < 128; hi++) begin
      for (int ctl = 0; ctl < 16; ctl++) begin
        logic [16:0] low;
        low    = 17'((hi * 4099 + ctl * 1237) & 17'h1FFFE);
        low[0] = ctl[3];
        apply({hi[6:0], low}, ctl[3:0]);
      end
    end
    // R2 window edges.
    edges[0] = 24'h0BFFFF;
    edges[1] = 24'h0C0000;
    edges[2] = 24'h1BFFFF;
    edges[3] = 24'h1C0000;
    for (int e = 0; e < 4; e++) begin
      for (int ctl = 0; ctl < 16; ctl++) begin
        logic [ADDR_W-1:0] a;
        a    = edges[e];
        a[0] = ctl[3];
        apply(a, ctl[3:0]);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule